// File: doc/BRIEF.md
# Compare Timer with Auto-Increment

This block is one timer frame that watches a free-running 64-bit system count supplied from outside and raises a level interrupt once the count reaches a programmed point. Software reaches it through a simple 32-bit register port. Writes take effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read strobe.

Two firing schemes are offered. In one-shot mode the frame holds a 64-bit absolute compare value, which can also be seen and written as a signed 32-bit distance from the current count. In auto-increment mode the frame keeps its own 64-bit firing point. Each time the count reaches that point, the point advances by a fixed reload interval and a sticky event flag is latched until software clears it. Firing depends only on the count value and not on elapsed clock cycles, so a slower or halted count delays the interrupt.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control register (offset 0x2C) reads 0, the interrupt output is low, and the auto-increment control (0x4C) reads 0.
- R2: Offsets 0x00 and 0x04 return the low and high 32 bits of the input count. Offset 0x10 returns the FREQ_HZ parameter.
- R3: The compare value is written at 0x20 (low half) and 0x24 (high half). While the timer is enabled (control bit 0) and auto-increment is off, control bit 2 (status) reads 1 whenever count >= compare, unsigned over all 64 bits. A jump past the compare point also sets it, and control then reads 5.
- R4: Reading offset 0x28 returns the low 32 bits of compare minus count. For example, compare 4000 at count 100 reads 3900.
- R5: Writing offset 0x28 sets compare to count plus the sign-extended 32-bit write data.
- R6: While control bit 0 is 0, the status bit reads 0 and the interrupt stays low.
- R7: The interrupt output is status AND NOT control bit 1 (the mask bit). With the mask set, status still reads in control bit 2 but the interrupt stays low.
- R8: Writing 0x4C with bit 0 = 1 while auto-increment is off turns it on. This loads the auto value (read at 0x40 low / 0x44 high) with count plus the reload interval (0x48) and clears the event flag (0x4C bit 1). In this mode, status equals the event flag.
- R9: In auto mode with the timer enabled, when count >= auto value the event flag sets and the auto value advances by the reload interval.
- R10: A write to 0x4C with bit 1 = 0 clears the event flag. With bit 1 = 1 the flag is kept. After clearing, the timer fires again at the next auto value.
- R11: A count held below the firing point never fires, however many cycles pass.
- R12: Writes to 0x00, 0x10 and 0x40 have no effect on what those offsets read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CW | System count value |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data, valid the cycle after bus_re |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
On every cycle, the assertions check the following. The status bit is never set with the timer disabled. The interrupt only follows an unmasked status. Each auto-increment firing advances the firing point by exactly the reload interval and raises the event flag. The event flag holds until a control write. The firing point stays frozen while auto mode is off. The bench scenarios show what the assertions cannot: the decoded register values, the relative-view arithmetic with negative distances, the high-half comparison when the count jumps, the clear-and-refire sequence, and that stray writes to read-only offsets leave the reads unchanged.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam logic [7:0] OFS_CNT_LO  = 8'h00;
  localparam logic [7:0] OFS_CNT_HI  = 8'h04;
  localparam logic [7:0] OFS_FREQ    = 8'h10;
  localparam logic [7:0] OFS_CMP_LO  = 8'h20;
  localparam logic [7:0] OFS_CMP_HI  = 8'h24;
  localparam logic [7:0] OFS_REL     = 8'h28;
  localparam logic [7:0] OFS_CTRL    = 8'h2C;
  localparam logic [7:0] OFS_AUTO_LO = 8'h40;
  localparam logic [7:0] OFS_AUTO_HI = 8'h44;
  localparam logic [7:0] OFS_RELOAD  = 8'h48;
  localparam logic [7:0] OFS_AUTOCTL = 8'h4C;
endpackage

// File: rtl/ct_ge.sv
module ct_ge #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         ge_o
);
  always_ff @(posedge clk) begin
    if (rst) ge_o <= 1'b0;
    else     ge_o <= (a_i >= b_i);
  end
endmodule

// File: rtl/ct_autoinc.sv
module ct_autoinc #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic [DW-1:0] reload_i,
  input  logic          tmr_en_i,
  input  logic          ctl_we_i,
  input  logic [1:0]    ctl_wd_i,
  output logic          ai_en_o,
  output logic          evt_o,
  output logic [CW-1:0] aival_o
);
  localparam int XW = CW - DW;

  logic          en_q, evt_q;
  logic [CW-1:0] point_q;
  logic [CW-1:0] step;
  logic          load, fire;

  assign step = {{XW{1'b0}}, reload_i};
  assign load = ctl_we_i && ctl_wd_i[0] && !en_q;
  assign fire = !ctl_we_i && en_q && tmr_en_i && (count_i >= point_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      evt_q   <= 1'b0;
      point_q <= '0;
    end else if (ctl_we_i) begin
      en_q <= ctl_wd_i[0];
      if (load) begin
        point_q <= count_i + step;
        evt_q   <= 1'b0;
      end else if (!ctl_wd_i[1]) begin
        evt_q <= 1'b0;
      end
    end else if (fire) begin
      evt_q   <= 1'b1;
      point_q <= point_q + step;
    end
  end

  assign ai_en_o = en_q;
  assign evt_o   = evt_q;
  assign aival_o = point_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int          CW      = 64,
  parameter int          DW      = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] FREQ_HZ = 32'd32_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  import ct_pkg::*;
  localparam int XW = CW - DW;

  logic          en_q, mask_q, irq_q;
  logic [CW-1:0] cval_q;
  logic [DW-1:0] reload_q, rdata_q;
  logic          cmp_ge, ai_en, ai_evt, status, ai_we;
  logic [CW-1:0] aival, rel_full;
  logic [DW-1:0] rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  assign ai_we    = bus_we && hit(bus_addr, OFS_AUTOCTL);
  assign rel_full = cval_q - count_i;

  ct_ge #(.W(CW)) u_ge (
    .clk(clk), .rst(rst), .a_i(count_i), .b_i(cval_q), .ge_o(cmp_ge)
  );

  ct_autoinc #(.CW(CW), .DW(DW)) u_auto (
    .clk(clk), .rst(rst), .count_i(count_i), .reload_i(reload_q),
    .tmr_en_i(en_q), .ctl_we_i(ai_we), .ctl_wd_i(bus_wdata[1:0]),
    .ai_en_o(ai_en), .evt_o(ai_evt), .aival_o(aival)
  );

  assign status = en_q && (ai_en ? ai_evt : cmp_ge);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      cval_q   <= '0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= status && !mask_q;
      if (bus_we) begin
        if (hit(bus_addr, OFS_CTRL)) begin
          en_q   <= bus_wdata[0];
          mask_q <= bus_wdata[1];
        end
        if (hit(bus_addr, OFS_CMP_LO)) cval_q[DW-1:0] <= bus_wdata;
        if (hit(bus_addr, OFS_CMP_HI)) cval_q[CW-1:DW] <= XW'(bus_wdata);
        if (hit(bus_addr, OFS_REL))
          cval_q <= count_i + {{XW{bus_wdata[DW-1]}}, bus_wdata};
        if (hit(bus_addr, OFS_RELOAD)) reload_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFS_CNT_LO))  rd_mux = count_i[DW-1:0];
    if (hit(bus_addr, OFS_CNT_HI))  rd_mux = DW'(count_i >> DW);
    if (hit(bus_addr, OFS_FREQ))    rd_mux = DW'(FREQ_HZ);
    if (hit(bus_addr, OFS_CMP_LO))  rd_mux = cval_q[DW-1:0];
    if (hit(bus_addr, OFS_CMP_HI))  rd_mux = DW'(cval_q >> DW);
    if (hit(bus_addr, OFS_REL))     rd_mux = rel_full[DW-1:0];
    if (hit(bus_addr, OFS_CTRL))    rd_mux = DW'({status, mask_q, en_q});
    if (hit(bus_addr, OFS_AUTO_LO)) rd_mux = aival[DW-1:0];
    if (hit(bus_addr, OFS_AUTO_HI)) rd_mux = DW'(aival >> DW);
    if (hit(bus_addr, OFS_RELOAD))  rd_mux = reload_q;
    if (hit(bus_addr, OFS_AUTOCTL)) rd_mux = DW'({ai_evt, ai_en});
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/ct_timer_chk.sv
module ct_timer_chk #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_o,
  input logic          en_q,
  input logic          mask_q,
  input logic          status,
  input logic          ai_en,
  input logic          ai_evt,
  input logic          ai_we,
  input logic [CW-1:0] aival,
  input logic [DW-1:0] reload_q,
  input logic [CW-1:0] count_i
);
  localparam int XW = CW - DW;

  AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !status); // R6
  AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(status && !mask_q)); // R7
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (rst)
    (ai_en && en_q && !ai_we && count_i >= aival) |=>
      (ai_evt && aival == $past(aival) + {{XW{1'b0}}, $past(reload_q)})); // R9
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ai_evt && !ai_we) |=> ai_evt); // R10
  AST_POINT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!ai_en && !ai_we) |=> $stable(aival)); // R8
endmodule

bind cmp_timer ct_timer_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .en_q(en_q), .mask_q(mask_q),
  .status(status), .ai_en(ai_en), .ai_evt(ai_evt), .ai_we(ai_we),
  .aival(aival), .reload_q(reload_q), .count_i(count_i)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam logic [31:0] FREQ = 32'd32_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_timer #(.FREQ_HZ(FREQ)) i_cmp_timer (
    .clk(clk), .rst(rst), .count_i(cnt), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    repeat (3) @(negedge clk);
    re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {32'd0, v}, {32'd0, exp});
  endtask

  task automatic set_cnt(input logic [63:0] v);
    @(negedge clk); cnt = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rchk("R1 ctrl", 8'h2C, 32'd0);
    rchk("R1 autoctl", 8'h4C, 32'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    rchk("R2 freq", 8'h10, FREQ);
    set_cnt(64'd0);
    rchk("R2 count lo", 8'h00, 32'd0);
  endtask

  task automatic t_oneshot;
    set_cnt(64'd100);
    wr(8'h20, 32'd4000);
    wr(8'h24, 32'd0);
    set_cnt(64'd5000);
    rchk("R6 disabled status", 8'h2C, 32'd0);
    chk("R6 irq", {63'd0, irq}, 64'd0);
    set_cnt(64'd100);
    wr(8'h2C, 32'd1);
    rchk("R4 rel view", 8'h28, 32'd3900);
    rchk("R3 before", 8'h2C, 32'd1);
    set_cnt(64'd4000);
    rchk("R3 fired", 8'h2C, 32'd5);
    rchk("R4 rel zero", 8'h28, 32'd0);
    chk("R7 irq on", {63'd0, irq}, 64'd1);
    wr(8'h2C, 32'd3);
    rchk("R7 masked ctrl", 8'h2C, 32'd7);
    chk("R7 irq masked", {63'd0, irq}, 64'd0);
    wr(8'h2C, 32'd0);
    rchk("R6 off ctrl", 8'h2C, 32'd0);
    wr(8'h2C, 32'd1);
  endtask

  task automatic t_wide;
    set_cnt(64'h42_0000_1130);
    wr(8'h20, 32'd0);
    wr(8'h24, 32'h43);
    rchk("R2 count hi", 8'h04, 32'h42);
    rchk("R2 count lo", 8'h00, 32'h1130);
    rchk("R3 high half below", 8'h2C, 32'd1);
    set_cnt(64'h43_0000_0005);
    rchk("R3 jump past", 8'h2C, 32'd5);
  endtask

  task automatic t_rel_write;
    set_cnt(64'd1000);
    wr(8'h28, 32'hFFFF_FF9C);
    rchk("R5 neg lo", 8'h20, 32'd900);
    rchk("R5 neg hi", 8'h24, 32'd0);
    rchk("R5 neg status", 8'h2C, 32'd5);
    wr(8'h28, 32'd50);
    rchk("R5 pos lo", 8'h20, 32'd1050);
    rchk("R5 pos status", 8'h2C, 32'd1);
  endtask

  task automatic t_auto;
    wr(8'h24, 32'hFFFF_FFFF);
    set_cnt(64'd4000);
    wr(8'h48, 32'd200);
    wr(8'h4C, 32'd1);
    rchk("R8 point lo", 8'h40, 32'd4200);
    rchk("R8 point hi", 8'h44, 32'd0);
    rchk("R8 status clear", 8'h2C, 32'd1);
    set_cnt(64'd4100);
    rchk("R11 not yet", 8'h2C, 32'd1);
    set_cnt(64'd4200);
    rchk("R9 fired", 8'h2C, 32'd5);
    rchk("R9 advanced", 8'h40, 32'd4400);
    rchk("R9 evt flag", 8'h4C, 32'd3);
    set_cnt(64'd4300);
    rchk("R10 sticky", 8'h2C, 32'd5);
    wr(8'h4C, 32'd3);
    rchk("R10 keep", 8'h2C, 32'd5);
    wr(8'h4C, 32'd1);
    rchk("R10 cleared", 8'h2C, 32'd1);
    set_cnt(64'd4399);
    repeat (50) @(negedge clk);
    rchk("R11 held count", 8'h2C, 32'd1);
    rchk("R11 point held", 8'h40, 32'd4400);
    set_cnt(64'd4400);
    rchk("R10 refire", 8'h2C, 32'd5);
    rchk("R10 next point", 8'h40, 32'd4600);
  endtask

  task automatic t_readonly;
    wr(8'h40, 32'd7);
    rchk("R12 point write", 8'h40, 32'd4600);
    wr(8'h00, 32'h55);
    rchk("R12 count write", 8'h00, 32'd4400);
    wr(8'h10, 32'd0);
    rchk("R12 freq write", 8'h10, FREQ);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_oneshot;
    t_wide;
    t_rel_write;
    t_auto;
    t_readonly;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule